// File: doc/BRIEF.md
# Serial 1101 Pattern Recognizer

This block watches a one-bit serial stream, taking one bit on each clock edge where its bit-enable is high, and raises a detect flag when the four most recent accepted bits are 1, 1, 0, 1. The oldest bit comes first. Matches may overlap: the final 1 of one match can also serve as the first 1 of the next match.

A parameter selects one of two output styles. In the combinational style, the flag rises in the same cycle that the final 1 is presented. It depends on the current state, the input bit and the enable. In the registered style, the machine has one extra state that it enters on a full match. The flag is decoded from that state alone, so it appears one cycle after the final bit. The state register uses binary encoding with the fewest bits that hold all the states: two bits for the combinational style and three bits for the registered style. The reset state is all zeros. Reset is synchronous and active low.

Top module: `seq1101_detect`

## Requirements
- R1: A clock edge with `rst_n` low returns the machine to the idle state. The next bits must then form a complete new 1101 before the flag rises, and in the registered style the flag is low after that edge.
- R2: With `MOORE`=0, `hit` is high in exactly the cycle in which an accepted bit 1 completes the sequence 1,1,0,1.
- R3: With `MOORE`=1, `hit` is high after the clock edge that accepts the completing 1, and low after the next accepted bit.
- R4: Detection overlaps. The accepted stream 1101101 produces two detections.
- R5: A run of three or more 1s followed by 0,1 is detected. Extra leading 1s keep the partial match of "11".
- R6: When `bit_en` is low, the bit is ignored and the state holds. With `MOORE`=0, `hit` is low in that cycle. With `MOORE`=1, `hit` keeps its value.
- R7: Streams that break a partial match resume correctly, with no false detection. For example, 110 followed by 0 returns to idle, and 10 followed by 1101 is detected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset to the idle state |
| bit_en | input | 1 | Qualifies `bit_in`; when low the bit is ignored |
| bit_in | input | 1 | Serial data bit |
| hit | output | 1 | Detect flag, combinational or registered per `MOORE` |

## Verification
The stimulus goes after overlap at the trailing 1. A design that returned to idle after a match would miss the second detection in 1101101. A run of 1s before 0,1 catches a design that drops back to idle on a third 1. A stream of 110 followed by 0 catches a design that treats 1100 as a partial match. Enable gaps are placed inside a partial match and in the final-bit cycle. A design that advanced on a disabled bit, or left the combinational flag ungated, would flag in the wrong cycle. A reset applied in the middle of 110 catches a design whose reset does not clear the partial match, because the following 1 would then raise the flag.

// File: rtl/seq1101_pkg.sv
// Package: state codes and state counts shared by the recognizer.
// Assumes binary state encoding with idle at code zero.
package seq1101_pkg;
    localparam int ST_IDLE      = 0;  // nothing useful seen
    localparam int ST_ONE       = 1;  // seen "1"
    localparam int ST_TWO       = 2;  // seen "11"
    localparam int ST_THREE     = 3;  // seen "110"
    localparam int ST_MATCH     = 4;  // registered style only: full match
    localparam int MEALY_STATES = 4;
    localparam int MOORE_STATES = 5;
endpackage

// File: rtl/seq1101_step.sv
// Module: next-state function of the 1101 recognizer.
// Assumes cur only holds legal codes. A disabled bit yields nxt == cur.
// MOORE selects whether a full match enters ST_MATCH or returns to ST_ONE.
module seq1101_step
    import seq1101_pkg::*;
#(
    parameter bit MOORE = 1'b0,
    parameter int SW    = 2
) (
    input  logic [SW-1:0] cur,
    input  logic          bit_in,
    input  logic          bit_en,
    output logic [SW-1:0] nxt
);

    // Purpose: choose the successor state from the present state and the bit.
    always_comb begin
        nxt = SW'(ST_IDLE);
        if (!bit_en)
            nxt = cur;
        else if (cur == SW'(ST_IDLE))
            nxt = bit_in ? SW'(ST_ONE) : SW'(ST_IDLE);
        else if (cur == SW'(ST_ONE))
            nxt = bit_in ? SW'(ST_TWO) : SW'(ST_IDLE);
        else if (cur == SW'(ST_TWO))
            nxt = bit_in ? SW'(ST_TWO) : SW'(ST_THREE);
        else if (cur == SW'(ST_THREE))
            nxt = bit_in ? (MOORE ? SW'(ST_MATCH) : SW'(ST_ONE)) : SW'(ST_IDLE);
        else if (MOORE && cur == SW'(ST_MATCH))
            nxt = bit_in ? SW'(ST_TWO) : SW'(ST_IDLE);
        else
            nxt = SW'(ST_IDLE);
    end

endmodule

// File: rtl/seq1101_statereg.sv
// Module: state register with synchronous active-low reset to all zeros.
// Assumes any hold on a disabled bit is already folded into d.
module seq1101_statereg #(
    parameter int SW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [SW-1:0] d,
    output logic [SW-1:0] q
);

    // Purpose: capture the next state, or clear it on reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            q <= '0;
        else
            q <= d;
    end

    // R1: a reset edge always leaves the idle code
    p_reset_idle_r1: assert property (@(posedge clk) !rst_n |=> (q == '0));

endmodule

// File: rtl/seq1101_detect.sv
// Module: top of the serial 1101 recognizer.
// MOORE=0 gives a combinational flag from four states. MOORE=1 gives a flag
// decoded from a fifth state. Assumes rst_n is synchronous to clk.
module seq1101_detect
    import seq1101_pkg::*;
#(
    parameter bit MOORE = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_en,
    input  logic bit_in,
    output logic hit
);

    localparam int NSTATE = MOORE ? MOORE_STATES : MEALY_STATES;
    localparam int SW     = $clog2(NSTATE);

    logic [SW-1:0] cur;
    logic [SW-1:0] nxt;

    seq1101_step #(.MOORE(MOORE), .SW(SW)) u_step (
        .cur    (cur),
        .bit_in (bit_in),
        .bit_en (bit_en),
        .nxt    (nxt)
    );

    seq1101_statereg #(.SW(SW)) u_reg (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (nxt),
        .q     (cur)
    );

    // R6: a disabled bit leaves the state untouched
    p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_en |=> $stable(cur));

    generate
        if (MOORE) begin : g_moore
            // Purpose: flag decoded from the match state only.
            assign hit = (cur == SW'(ST_MATCH));

            // R3: the flag only rises after an accepted 1
            p_moore_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(hit) |-> $past(bit_en && bit_in));
            // R4: an accepted bit always leaves the match state
            p_moore_leave_r4: assert property (@(posedge clk) disable iff (!rst_n)
                (hit && bit_en) |=> !hit);
            // R7: the register never holds a code above the match state
            p_legal_code_r7: assert property (@(posedge clk) disable iff (!rst_n)
                cur <= SW'(ST_MATCH));
        end else begin : g_mealy
            // Purpose: flag on the transition out of "110" taken by an accepted 1.
            assign hit = bit_en && bit_in && (cur == SW'(ST_THREE));

            // R2: the flag never rises without an accepted 1 at the port
            p_mealy_fire_r2: assert property (@(posedge clk) disable iff (!rst_n)
                hit |-> (bit_en && bit_in));
            // R4: after a detection the machine has seen "1", so no flag next cycle
            p_mealy_gap_r4: assert property (@(posedge clk) disable iff (!rst_n)
                hit |=> !hit);
        end
    endgenerate

endmodule

// File: tb/sim_seq1101_detect.sv
`timescale 1ns/1ps
module sim_seq1101_detect;

    // Each vector: {bit_en, bit_in, expected combinational hit, expected registered hit after edge}
    localparam int NVEC = 40;
    localparam logic [3:0] VEC [NVEC] = '{
        4'b1100, 4'b1100, 4'b1000, 4'b1111,                       // 0-3  R2 R3
        4'b1100, 4'b1000, 4'b1111,                                // 4-6  R4
        4'b1100, 4'b1100, 4'b1100, 4'b1000, 4'b1111,              // 7-11 R5
        4'b1000, 4'b1100, 4'b0000, 4'b1100, 4'b0100, 4'b1000,     // 12-17 R6
        4'b0100, 4'b1111, 4'b0101, 4'b0001,                       // 18-21 R6
        4'b1000, 4'b1100, 4'b1000, 4'b1100, 4'b1100, 4'b1000,     // 22-27 R7
        4'b1000, 4'b1100, 4'b1100, 4'b1000, 4'b1111,              // 28-32 R7
        4'b1000, 4'b1100, 4'b1000, 4'b1100, 4'b1100, 4'b1000,     // 33-38 R7
        4'b1111                                                   // 39   R7
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bit_en = 1'b0;
    logic bit_in = 1'b0;
    logic hit_mealy;
    logic hit_moore;
    int   n_chk = 0;
    int   n_bad = 0;
    bit   done = 1'b0;

    always #2.5 clk = ~clk;

    seq1101_detect #(.MOORE(1'b0)) u0 (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .bit_in(bit_in), .hit(hit_mealy)
    );
    seq1101_detect #(.MOORE(1'b1)) u1 (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .bit_in(bit_in), .hit(hit_moore)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    // Drive one bit; check the combinational flag before the edge, the registered flag after it.
    task automatic step(input logic e, input logic b, input logic xm, input logic xo,
                        input string rm, input string ro);
        @(negedge clk);
        bit_en = e;
        bit_in = b;
        #1 chk(rm, hit_mealy, xm);
        @(posedge clk);
        #1 chk(ro, hit_moore, xo);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        bit_en = 1'b0;
        bit_in = 1'b0;
        @(posedge clk);
        #1;
        chk("R1 moore", hit_moore, 1'b0);
        chk("R1 mealy", hit_mealy, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    function automatic string tag_of(input int i, input bit moore);
        if (i < 4)  return moore ? "R3" : "R2";
        if (i < 7)  return "R4";
        if (i < 12) return "R5";
        if (i < 22) return "R6";
        return "R7";
    endfunction

    initial begin
        repeat (2) @(posedge clk);
        #1;
        chk("R1 initial moore", hit_moore, 1'b0);
        chk("R1 initial mealy", hit_mealy, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < NVEC; i++) begin
            step(VEC[i][3], VEC[i][2], VEC[i][1], VEC[i][0], tag_of(i, 1'b0), tag_of(i, 1'b1));
        end

        // R1: reset clears the registered match flag
        do_reset();
        // R1: reset in the middle of "110" discards the partial match
        step(1'b1, 1'b1, 1'b0, 1'b0, "R1", "R1");
        step(1'b1, 1'b1, 1'b0, 1'b0, "R1", "R1");
        step(1'b1, 1'b0, 1'b0, 1'b0, "R1", "R1");
        do_reset();
        step(1'b1, 1'b1, 1'b0, 1'b0, "R1 after reset", "R1 after reset");
        step(1'b1, 1'b1, 1'b0, 1'b0, "R1", "R1");
        step(1'b1, 1'b0, 1'b0, 1'b0, "R1", "R1");
        step(1'b1, 1'b1, 1'b1, 1'b1, "R1 fresh match", "R1 fresh match");
        // R3: the registered flag lasts a single accepted bit
        step(1'b1, 1'b1, 1'b0, 1'b0, "R3", "R3");

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

endmodule